// File: doc/BRIEF.md
# Firmware staging mailbox target

This block is the device end of a small memory-mapped mailbox through which a host pushes a firmware image one chunk at a time. The host sees four dword registers on a plain 32-bit write/read port. The registers are control, status, write-data and read-data. A request object is built from single-dword writes to the write-data register: a 64-bit mailbox header, then a 64-bit command, then the chunk dwords. The host then issues a go command on the control register. The target checks the object, streams the accepted chunk out of its internal buffer to a downstream consumer, and flags ready, or ready plus error. It then offers a four-dword response on the read-data register.

The target decides which part of the image the host sends next. It tracks the byte offset reached so far and adds the size of each accepted chunk. Once a configured image length is reached, it answers with an all-ones end marker. Read data moves on to the next response dword only when the host writes to the read-data register. An abort bit in the control register returns the whole mailbox to its reset state at any time.

The chunk output is a valid/ready stream. Once `chk_vld` is raised, `chk_data` and `chk_last` hold steady until the consumer accepts with `chk_rdy`. The consumer may hold `chk_rdy` low for any number of cycles. The mailbox stays busy, and reports neither ready nor error, until the final dword has been accepted.

Top module: `mbx_stage_target`

## Requirements
- R1: Registers are selected by byte-address bits 3:2: 0 control, 1 status, 2 write-data, 3 read-data. After reset the status register reads 0, the read-data register reads 0, control and write-data read 0, and `chk_vld` is low.
- R2: Write-data dwords are taken in order: header low, header high (object length in dwords), command low, command high, then chunk dwords. After an accepted go, the chunk dwords appear on the stream in write order. `chk_last` is high only on the final one, and data and last hold while `chk_rdy` is low.
- R3: For a well-formed request, status reads 0x8000_0000 (bit 31 ready, bit 2 clear) from the cycle after the last stream handshake, and not before.
- R4: A go is rejected when any of these holds: the dword count differs from the header length; the 64-bit command is not 3; fewer than one chunk dword was written; more than CHUNK_DW chunk dwords were written. A rejected go sets status to 0x8000_0004 (ready and error) and produces no stream output.
- R5: The response, read in order, is: header low = 0x000B_0000 | VENDOR_ID; header high = 4; next offset; status word. In the status word, bit 0 means success, bit 1 means more chunks wanted, and bit 2 means error.
- R6: On success, next = offset + 4 × chunk dwords. If next ≥ `img_len_bytes`, the response gives 0xFFFF_FFFF with status 1 and the tracked offset returns to 0. Otherwise it gives next with status 3 and the offset becomes next. A rejected request reports the unchanged offset with status 4.
- R7: Reading read-data does not advance it. A write to read-data while ready advances it by one dword. After four advances it reads 0. Before ready it reads 0, and writes to it are ignored.
- R8: The first write-data dword after a completed transaction clears ready and error.
- R9: A control write with bit 0 set aborts. On the next cycle status is 0 and `chk_vld` is low. The partial request is discarded and the tracked offset returns to 0. Abort wins over a go bit written in the same word.
- R10: While the chunk is being streamed, go commands and write-data writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Byte-address bits 3:2 selecting the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |
| img_len_bytes | input | 32 | Length of the image in bytes, for the offset policy |
| chk_vld | output | 1 | Chunk stream valid |
| chk_rdy | input | 1 | Chunk stream ready from the consumer |
| chk_data | output | 32 | Chunk stream dword |
| chk_last | output | 1 | Marks the final dword of the chunk |

## Verification
The checker presumes a host that changes the register port only between clock edges and issues at most one access per cycle. It also presumes that the consumer may stall freely but never sees an abort counted as back-pressure: the hold property is armed only in cycles with no abort. The bench drives every input one time unit after the rising edge and samples combinational read data at the falling edge. It sweeps chunk sizes 1 to 4 against several image lengths, including one that is not a multiple of four, and uses varied stall patterns. It also steps through each rejection rule, aborts in every phase, and sends stray go and write-data traffic during a stalled stream.

// File: rtl/mbx_stage_pkg.sv
package mbx_stage_pkg;

  typedef enum logic [1:0] {
    PH_FILL  = 2'd0,
    PH_DRAIN = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_WDAT = 2'd2;
  localparam logic [1:0] SEL_RDAT = 2'd3;

  localparam int CTRL_ABORT = 0;
  localparam int CTRL_GO    = 31;
  localparam int STAT_READY = 31;
  localparam int STAT_ERR   = 2;

  localparam int HDR_DW = 4;

  localparam logic [7:0]  OBJ_STAGE   = 8'h0B;
  localparam logic [31:0] CMD_LOAD    = 32'h0000_0003;
  localparam logic [31:0] END_MARK    = 32'hFFFF_FFFF;
  localparam logic [31:0] RESP_LEN_DW = 32'd4;

  localparam logic [31:0] RS_DONE_OK = 32'h0000_0001;
  localparam logic [31:0] RS_MORE    = 32'h0000_0003;
  localparam logic [31:0] RS_FAIL    = 32'h0000_0004;

endpackage

// File: rtl/mbx_req_asm.sv
module mbx_req_asm
  import mbx_stage_pkg::*;
#(
  parameter int CHUNK_DW = 16,
  parameter int CNT_W    = 16,
  localparam int PTR_W   = (CHUNK_DW > 1) ? $clog2(CHUNK_DW) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             first,
  input  logic [31:0]      din,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] cnt,
  output logic [31:0]      len_dw,
  output logic [31:0]      cmd_lo,
  output logic [31:0]      cmd_hi,
  output logic [31:0]      rd_data
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic [CNT_W-1:0]    idx;
  logic [CHUNK_DW-1:0] slot_hit;
  logic [31:0]         mem [CHUNK_DW];

  // a request starting after a finished transaction restarts at index 0
  assign idx = first ? '0 : cnt;

  for (genvar g = 0; g < CHUNK_DW; g++) begin : g_slot
    assign slot_hit[g] = push && (idx == CNT_W'(HDR_DW + g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      len_dw <= '0;
      cmd_lo <= '0;
      cmd_hi <= '0;
    end else if (flush) begin
      cnt <= '0;
    end else if (push) begin
      cnt <= (idx == CNT_SAT) ? idx : idx + CNT_W'(1);
      if (idx == CNT_W'(1)) len_dw <= din;
      if (idx == CNT_W'(2)) cmd_lo <= din;
      if (idx == CNT_W'(3)) cmd_hi <= din;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < CHUNK_DW; i++) begin
      if (slot_hit[i]) mem[i] <= din;
    end
  end

  assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/mbx_drain.sv
module mbx_drain #(
  parameter int CHUNK_DW = 16,
  localparam int PTR_W   = (CHUNK_DW > 1) ? $clog2(CHUNK_DW) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             start,
  input  logic [PTR_W-1:0] last_idx,
  input  logic             out_rdy,
  output logic             out_vld,
  output logic             out_last,
  output logic [PTR_W-1:0] ptr,
  output logic             done
);

  logic             act_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] end_q;

  assign out_vld  = act_q;
  assign out_last = act_q && (ptr_q == end_q);
  assign done     = act_q && out_rdy && out_last;
  assign ptr      = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ptr_q <= '0;
      end_q <= '0;
    end else if (flush) begin
      act_q <= 1'b0;
      ptr_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      ptr_q <= '0;
      end_q <= last_idx;
    end else if (act_q && out_rdy) begin
      if (out_last) act_q <= 1'b0;
      else          ptr_q <= ptr_q + PTR_W'(1);
    end
  end

endmodule

// File: rtl/mbx_resp.sv
module mbx_resp
  import mbx_stage_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h5A3C,
  parameter int CHUNK_DW = 16,
  parameter int CNT_W    = 16,
  localparam int PTR_W   = (CHUNK_DW > 1) ? $clog2(CHUNK_DW) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             go,
  input  logic             restart,
  input  logic             ack,
  input  logic [CNT_W-1:0] cnt,
  input  logic [31:0]      len_dw,
  input  logic [31:0]      cmd_lo,
  input  logic [31:0]      cmd_hi,
  input  logic [31:0]      img_len,
  output logic             bad,
  output logic [PTR_W-1:0] last_idx,
  output logic [31:0]      word
);

  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(HDR_DW + 1);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(HDR_DW + CHUNK_DW);

  logic [31:0]      cur_q;
  logic [31:0]      off_q;
  logic [31:0]      stat_q;
  logic [2:0]       ridx_q;
  logic [CNT_W-1:0] ndata;
  logic [31:0]      nbytes;
  logic [32:0]      next_sum;
  logic             end_hit;

  assign ndata    = cnt - CNT_W'(HDR_DW);
  assign nbytes   = 32'(ndata) << 2;
  assign next_sum = {1'b0, cur_q} + {1'b0, nbytes};
  assign end_hit  = next_sum >= {1'b0, img_len};
  assign last_idx = PTR_W'(ndata - CNT_W'(1));

  assign bad = (cnt < MIN_CNT) || (cnt > MAX_CNT) ||
               (len_dw != 32'(cnt)) ||
               (cmd_lo != CMD_LOAD) || (cmd_hi != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      off_q  <= '0;
      stat_q <= '0;
      ridx_q <= '0;
    end else if (flush) begin
      cur_q  <= '0;
      ridx_q <= '0;
    end else begin
      if (go) begin
        if (bad) begin
          off_q  <= cur_q;
          stat_q <= RS_FAIL;
        end else if (end_hit) begin
          off_q  <= END_MARK;
          stat_q <= RS_DONE_OK;
          cur_q  <= '0;
        end else begin
          off_q  <= next_sum[31:0];
          stat_q <= RS_MORE;
          cur_q  <= next_sum[31:0];
        end
      end
      if (go || restart)                ridx_q <= '0;
      else if (ack && ridx_q != 3'd4)   ridx_q <= ridx_q + 3'd1;
    end
  end

  always_comb begin
    unique case (ridx_q)
      3'd0:    word = {8'h00, OBJ_STAGE, VENDOR_ID};
      3'd1:    word = RESP_LEN_DW;
      3'd2:    word = off_q;
      3'd3:    word = stat_q;
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/mbx_stage_target.sv
module mbx_stage_target
  import mbx_stage_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h5A3C,
  parameter int CHUNK_DW = 16,
  parameter int CNT_W    = 16
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:2]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] img_len_bytes,
  output logic        chk_vld,
  input  logic        chk_rdy,
  output logic [31:0] chk_data,
  output logic        chk_last
);

  localparam int PTR_W = (CHUNK_DW > 1) ? $clog2(CHUNK_DW) : 1;

  phase_e           phase_q;
  logic             err_q;
  logic             ready_w;
  logic             wr_ctrl, wr_wdat, wr_rdat;
  logic             abort, go, push, restart, ack;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      len_dw, cmd_lo, cmd_hi;
  logic             req_bad;
  logic [PTR_W-1:0] last_idx;
  logic [PTR_W-1:0] drain_ptr;
  logic             drain_done;
  logic [31:0]      resp_word;

  assign wr_ctrl = reg_wr && (reg_addr == SEL_CTRL);
  assign wr_wdat = reg_wr && (reg_addr == SEL_WDAT);
  assign wr_rdat = reg_wr && (reg_addr == SEL_RDAT);

  assign abort   = wr_ctrl && reg_wdata[CTRL_ABORT];
  assign go      = wr_ctrl && reg_wdata[CTRL_GO] && !reg_wdata[CTRL_ABORT] &&
                   (phase_q == PH_FILL);
  assign push    = wr_wdat && (phase_q != PH_DRAIN);
  assign restart = push && (phase_q == PH_DONE);
  assign ack     = wr_rdat && (phase_q == PH_DONE);
  assign ready_w = (phase_q == PH_DONE);

  mbx_req_asm #(.CHUNK_DW(CHUNK_DW), .CNT_W(CNT_W)) u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (abort),
    .push    (push),
    .first   (restart),
    .din     (reg_wdata),
    .rd_ptr  (drain_ptr),
    .cnt     (cnt),
    .len_dw  (len_dw),
    .cmd_lo  (cmd_lo),
    .cmd_hi  (cmd_hi),
    .rd_data (chk_data)
  );

  mbx_resp #(.VENDOR_ID(VENDOR_ID), .CHUNK_DW(CHUNK_DW), .CNT_W(CNT_W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (abort),
    .go       (go),
    .restart  (restart),
    .ack      (ack),
    .cnt      (cnt),
    .len_dw   (len_dw),
    .cmd_lo   (cmd_lo),
    .cmd_hi   (cmd_hi),
    .img_len  (img_len_bytes),
    .bad      (req_bad),
    .last_idx (last_idx),
    .word     (resp_word)
  );

  mbx_drain #(.CHUNK_DW(CHUNK_DW)) u_drain (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (abort),
    .start    (go && !req_bad),
    .last_idx (last_idx),
    .out_rdy  (chk_rdy),
    .out_vld  (chk_vld),
    .out_last (chk_last),
    .ptr      (drain_ptr),
    .done     (drain_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FILL;
      err_q   <= 1'b0;
    end else if (abort) begin
      phase_q <= PH_FILL;
      err_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_FILL:  if (go) begin
                    phase_q <= req_bad ? PH_DONE : PH_DRAIN;
                    err_q   <= req_bad;
                  end
        PH_DRAIN: if (drain_done) phase_q <= PH_DONE;
        PH_DONE:  if (push) begin
                    phase_q <= PH_FILL;
                    err_q   <= 1'b0;
                  end
        default:  phase_q <= PH_FILL;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      SEL_STAT: begin
        reg_rdata[STAT_READY] = ready_w;
        reg_rdata[STAT_ERR]   = err_q;
      end
      SEL_RDAT: reg_rdata = ready_w ? resp_word : '0;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mbx_stage_chk.sv
module mbx_stage_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [3:2]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        chk_vld,
  input logic        chk_rdy,
  input logic [31:0] chk_data,
  input logic        chk_last,
  input logic        st_ready,
  input logic        st_err
);

  logic abort_now;
  assign abort_now = reg_wr && (reg_addr == 2'd0) && reg_wdata[0];

  p_err_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |-> st_ready);

  p_quiet_when_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready |-> !chk_vld);

  p_hold_on_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld && !chk_rdy && !abort_now) |=>
      (chk_vld && $stable(chk_data) && $stable(chk_last)));

  p_last_ends_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld && chk_rdy && chk_last && !abort_now) |=> (!chk_vld && st_ready));

  p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_now |=> (!st_ready && !st_err && !chk_vld));

  p_header_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && st_ready) |=> (!st_ready && !st_err));

  p_rdata_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_ready && reg_addr == 2'd3) |-> (reg_rdata == 32'd0));

endmodule

bind mbx_stage_target mbx_stage_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .chk_vld   (chk_vld),
  .chk_rdy   (chk_rdy),
  .chk_data  (chk_data),
  .chk_last  (chk_last),
  .st_ready  (ready_w),
  .st_err    (err_q)
);

// File: tb/test_mbx_stage_target.sv
module test_mbx_stage_target;

  localparam int          CDW = 4;
  localparam logic [15:0] VID = 16'h5A3C;
  localparam logic [31:0] HLO = {8'h00, 8'h0B, VID};
  localparam logic [31:0] GO  = 32'h8000_0000;
  localparam logic [31:0] ABT = 32'h0000_0001;
  localparam logic [31:0] ENDM = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:2]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] img_len = 32'd1000;
  logic        chk_vld;
  logic        chk_rdy = 1'b0;
  logic [31:0] chk_data;
  logic        chk_last;

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] model_off = '0;
  logic        last_end = 1'b0;
  logic        finished = 1'b0;

  always #2 clk = ~clk;

  mbx_stage_target #(.VENDOR_ID(VID), .CHUNK_DW(CDW), .CNT_W(16)) i_mbx_stage_target (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .img_len_bytes (img_len),
    .chk_vld       (chk_vld),
    .chk_rdy       (chk_rdy),
    .chk_data      (chk_data),
    .chk_last      (chk_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    @(posedge clk); #1;
  endtask

  task automatic send_req(input int nd, input logic [31:0] len_f, input logic [31:0] c_lo,
                          input logic [31:0] c_hi, input logic [31:0] base);
    logic [31:0] v;
    wr(2'd2, HLO);
    rd(2'd1, v); check("R8 header write clears status", v, 32'h0);
    wr(2'd2, len_f);
    wr(2'd2, c_lo);
    wr(2'd2, c_hi);
    for (int i = 0; i < nd; i++) wr(2'd2, base + 32'(i));
  endtask

  task automatic drain(input int n, input logic [31:0] base, input int pat, input string tag);
    int got = 0;
    for (int cyc = 0; cyc < 200 && got < n; cyc++) begin
      chk_rdy = (pat == 0) || (((cyc + pat) % 3) != 0);
      if (chk_vld && chk_rdy) begin
        check({"R2 chunk data ", tag}, chk_data, base + 32'(got));
        check({"R2 last flag ", tag}, 32'(chk_last), 32'(got == n - 1));
        got++;
      end
      @(posedge clk); #1;
    end
    chk_rdy = 1'b0;
    check({"R2 dword count ", tag}, 32'(got), 32'(n));
    check({"R2 stream idle ", tag}, 32'(chk_vld), 32'h0);
  endtask

  task automatic read_resp(input logic [31:0] eo, input logic [31:0] es, input string tag);
    logic [31:0] v;
    logic [31:0] exp_w [4];
    exp_w[0] = HLO; exp_w[1] = 32'd4; exp_w[2] = eo; exp_w[3] = es;
    rd(2'd3, v); check({"R7 read does not advance ", tag}, v, HLO);
    for (int k = 0; k < 4; k++) begin
      rd(2'd3, v);
      check((k == 2) ? {"R6 next offset ", tag} : {"R5 response word ", tag}, v, exp_w[k]);
      wr(2'd3, 32'h0);
    end
    rd(2'd3, v); check({"R7 exhausted response ", tag}, v, 32'h0);
  endtask

  task automatic finish_good(input int nd, input logic [31:0] base, input int pat, input string tag);
    logic [31:0] v, eo, es;
    longint s;
    drain(nd, base, pat, tag);
    rd(2'd1, v); check({"R3 ready status ", tag}, v, 32'h8000_0000);
    s = longint'(model_off) + 4 * nd;
    if (s >= longint'(img_len)) begin
      eo = ENDM; es = 32'h1; model_off = '0; last_end = 1'b1;
    end else begin
      eo = 32'(s); es = 32'h3; model_off = 32'(s); last_end = 1'b0;
    end
    read_resp(eo, es, tag);
  endtask

  task automatic good_req(input int nd, input int pat, input logic [31:0] base, input string tag);
    logic [31:0] v;
    send_req(nd, 32'(4 + nd), 32'h3, 32'h0, base);
    wr(2'd0, GO);
    if (pat != 0) begin
      chk_rdy = 1'b0;
      rd(2'd1, v); check({"R3 not ready while streaming ", tag}, v, 32'h0);
    end
    finish_good(nd, base, pat, tag);
  endtask

  task automatic bad_req(input int nd, input logic [31:0] len_f, input logic [31:0] c_lo,
                         input logic [31:0] c_hi, input string tag);
    logic [31:0] v;
    send_req(nd, len_f, c_lo, c_hi, 32'hB000);
    wr(2'd0, GO);
    check({"R4 no stream ", tag}, 32'(chk_vld), 32'h0);
    rd(2'd1, v); check({"R4 error status ", tag}, v, 32'h8000_0004);
    check({"R4 no stream later ", tag}, 32'(chk_vld), 32'h0);
    read_resp(model_off, 32'h4, tag);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    rd(2'd1, v); check("R1 status after reset", v, 32'h0);
    rd(2'd3, v); check("R1 read-data after reset", v, 32'h0);
    rd(2'd0, v); check("R1 control reads zero", v, 32'h0);
    rd(2'd2, v); check("R1 write-data reads zero", v, 32'h0);
    check("R1 stream idle after reset", 32'(chk_vld), 32'h0);

    // sweep chunk sizes against several image lengths
    for (int li = 0; li < 3; li++) begin
      img_len = (li == 0) ? 32'd24 : (li == 1) ? 32'd32 : 32'd13;
      wr(2'd0, ABT); model_off = '0;
      for (int nd = 1; nd <= CDW; nd++) begin
        for (int it = 0; it < 12; it++) begin
          good_req(nd, (nd + it) % 4, 32'h1000 * 32'(nd) + 32'h10 * 32'(it), "sweep");
          if (last_end) break;
        end
        check("R6 image end reached", 32'(last_end), 32'h1);
      end
    end

    // rejection rules with a non-zero tracked offset
    img_len = 32'd1000;
    wr(2'd0, ABT); model_off = '0;
    good_req(2, 0, 32'h2000, "pre-error");
    bad_req(2, 32'd6, 32'h5, 32'h0, "bad command");
    bad_req(2, 32'd6, 32'h3, 32'h1, "bad command high");
    bad_req(2, 32'd7, 32'h3, 32'h0, "length mismatch");
    bad_req(0, 32'd4, 32'h3, 32'h0, "no chunk dwords");
    bad_req(CDW + 1, 32'(4 + CDW + 1), 32'h3, 32'h0, "oversize chunk");
    good_req(3, 1, 32'h2100, "after errors R6");

    // read-data before ready, go and writes during streaming
    send_req(2, 32'd6, 32'h3, 32'h0, 32'h3000);
    rd(2'd3, v); check("R7 read-data zero before ready", v, 32'h0);
    wr(2'd3, 32'h0);
    wr(2'd0, GO);
    chk_rdy = 1'b0;
    wr(2'd2, 32'hDEAD_BEEF);
    wr(2'd0, GO);
    wr(2'd2, 32'h0000_0007);
    finish_good(2, 32'h3000, 2, "R10 ignored traffic");
    good_req(1, 0, 32'h3100, "R10 clean follow-up");

    // abort while streaming
    send_req(3, 32'd7, 32'h3, 32'h0, 32'h4000);
    wr(2'd0, GO);
    chk_rdy = 1'b0;
    wr(2'd0, ABT);
    check("R9 stream stops on abort", 32'(chk_vld), 32'h0);
    rd(2'd1, v); check("R9 status cleared by abort", v, 32'h0);
    model_off = '0;
    good_req(1, 0, 32'h4100, "R9 offset restarts");

    // abort mid-fill discards the partial request
    wr(2'd2, HLO);
    wr(2'd2, 32'd6);
    wr(2'd0, ABT);
    model_off = '0;
    good_req(2, 3, 32'h5000, "R9 after partial fill");

    // abort and go in the same word
    send_req(2, 32'd6, 32'h3, 32'h0, 32'h6000);
    wr(2'd0, 32'h8000_0001);
    check("R9 abort beats go stream", 32'(chk_vld), 32'h0);
    repeat (3) @(posedge clk);
    #1;
    rd(2'd1, v); check("R9 abort beats go status", v, 32'h0);
    model_off = '0;
    good_req(4, 0, 32'h6100, "R9 after combined word");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule